// File: doc/BRIEF.md
# Single-Wire Gamepad Device Responder

This block is the controller end of a half-duplex gamepad link that shares one open-drain wire with a host. The wire rests high. Either side sends a bit by pulling it low for a short or long part of a fixed cell. The block watches the wire and decodes the host's pulse-width bits. When it sees the 24-bit poll command and a valid stop bit, it waits a short gap and answers with a 64-bit status frame, then its own stop bit. It then lets go of the wire and listens for the next poll.

The frame is built from twelve button inputs and six 8-bit analog inputs. All of these are captured at the moment the reply starts. Timing is set by a clock-cycles-per-microsecond parameter. Each bit cell is 4 µs long. The block pulls the wire low through a drive-enable output and reads it back through a sampled input.

Top module: `sw_pad_responder`

## Requirements
- R1: During and after reset, and while no poll has arrived, `line_drive_o` is 0.
- R2: The block reads each host bit from the wire 2 µs after that bit's falling edge: a low sample is 0 and a high sample is 1. The 24 bits 0x400302 sent MSB first, followed by a stop bit that reads 1, start a reply.
- R3: Each reply bit cell lasts 4 µs. A 0 is driven low for 3 µs and then released for 1 µs. A 1 is driven low for 1 µs and then released for 3 µs.
- R4: The reply is exactly 65 bits: the 64-bit frame MSB first, then a stop bit of 1. After that the line is released and stays undriven.
- R5: Frame bits 63..56 (byte 0) hold 0,0,0,Start,Y,X,B,A. These come from `btn_i[4:0]` as [4]Start [3]Y [2]X [1]B [0]A.
- R6: Frame bits 55..48 (byte 1) hold 1,L,R,Z,up,down,right,left. These come from `btn_i[11:5]` as [11]L [10]R [9]Z [8]up [7]down [6]right [5]left.
- R7: Frame bits 47..0 hold, from the MSB down, main X, main Y, sub X, sub Y, left trigger and right trigger, each 8 bits.
- R8: Any other 24-bit command, or the poll command followed by a stop bit that reads 0, gives no reply.
- R9: If no falling edge arrives for 8 µs in the middle of a command, the partial command is dropped. A complete poll sent afterwards is answered.
- R10: Button and analog inputs are captured when the reply starts. Changes made during the reply do not alter the frame being sent.
- R11: While replying, the block does not decode its own pulses. After its stop bit it answers the next poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared wire |
| line_drive_o | output | 1 | 1 pulls the wire low |
| btn_i | input | 12 | Digital buttons, packed as in R5/R6 |
| main_x_i | input | 8 | Main stick X |
| main_y_i | input | 8 | Main stick Y |
| sub_x_i | input | 8 | Second stick X |
| sub_y_i | input | 8 | Second stick Y |
| trig_l_i | input | 8 | Left trigger analog |
| trig_r_i | input | 8 | Right trigger analog |

## Verification
The assertions check the following on every cycle:
- each low pulse the block drives is 1 µs or 3 µs long;
- successive pulses within a reply start exactly one cell apart;
- the wire is driven only while a reply is in progress, and is released at the stop bit;
- no command is decoded while the block is sending.

Only the bench's host scenarios can show the rest:
- the frame's field layout;
- the rejection of wrong commands and bad stop bits;
- the mid-command timeout;
- the capture of inputs at the start of the reply;
- back-to-back polls.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int CMD_BITS   = 24;
  localparam int FRAME_BITS = 64;
  localparam logic [CMD_BITS-1:0] POLL_CMD = 24'h400302;

  typedef enum logic [1:0] {ST_LISTEN, ST_GAP, ST_SEND} resp_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic [11:0] btn,
      input logic [7:0]  mx, my, sx, sy, tl, tr);
    return {3'b000, btn[4:0], 1'b1, btn[11:5], mx, my, sx, sy, tl, tr};
  endfunction
endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/swp_rx.sv
module swp_rx
  import swp_pkg::*;
#(
  parameter int US         = 16,
  parameter int TIMEOUT_US = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  input  logic fall_i,
  output logic cmd_ok_o
);
  localparam int SAMPLE_N  = 2 * US;
  localparam int TIMEOUT_N = TIMEOUT_US * US;
  localparam int CW        = $clog2(TIMEOUT_N + 1);
  localparam int BW        = $clog2(CMD_BITS + 2);
  localparam logic [CW-1:0] SAMPLE_C = CW'(SAMPLE_N);
  localparam logic [CW-1:0] TO_C     = CW'(TIMEOUT_N);
  localparam logic [BW-1:0] LAST_C   = BW'(CMD_BITS);

  logic [CW-1:0]       cnt_q;
  logic                armed_q;
  logic [BW-1:0]       nbits_q;
  logic [CMD_BITS-1:0] shreg_q;
  logic                cmd_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      nbits_q  <= '0;
      shreg_q  <= '0;
      cmd_ok_q <= 1'b0;
    end else begin
      cmd_ok_q <= 1'b0;
      if (!en_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        nbits_q <= '0;
      end else if (fall_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (cnt_q != TO_C) cnt_q <= cnt_q + 1'b1;
        if (armed_q && cnt_q == SAMPLE_C) begin
          armed_q <= 1'b0;
          if (nbits_q == LAST_C) begin
            // stop bit: must read high
            nbits_q  <= '0;
            cmd_ok_q <= (shreg_q == POLL_CMD) && line_i;
          end else begin
            nbits_q <= nbits_q + 1'b1;
            shreg_q <= {shreg_q[CMD_BITS-2:0], line_i};
          end
        end else if (nbits_q != '0 && cnt_q == TO_C) begin
          nbits_q <= '0;  // stalled mid-command
        end
      end
    end
  end

  assign cmd_ok_o = cmd_ok_q;
endmodule

// File: rtl/swp_tx.sv
module swp_tx #(
  parameter int US         = 16,
  parameter int FRAME_BITS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  drive_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int NBITS = FRAME_BITS + 1;
  localparam int CELL  = 4 * US;
  localparam int CW    = $clog2(CELL + 1);
  localparam int IW    = $clog2(NBITS);
  localparam logic [CW-1:0] CELL_END_C = CW'(CELL - 1);
  localparam logic [CW-1:0] ONE_LOW_C  = CW'(US);
  localparam logic [CW-1:0] ZERO_LOW_C = CW'(3 * US);
  localparam logic [IW-1:0] LAST_IDX_C = IW'(NBITS - 1);

  logic [NBITS-1:0] sh_q;
  logic [CW-1:0]    cyc_q;
  logic [IW-1:0]    idx_q;
  logic             busy_q;
  logic             done_q;
  logic [CW-1:0]    low_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cyc_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !busy_q) begin
        sh_q   <= {frame_i, 1'b1};  // frame then stop bit
        cyc_q  <= '0;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cyc_q == CELL_END_C) begin
          cyc_q <= '0;
          sh_q  <= {sh_q[NBITS-2:0], 1'b0};
          if (idx_q == LAST_IDX_C) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  assign low_len = sh_q[NBITS-1] ? ONE_LOW_C : ZERO_LOW_C;
  assign drive_o = busy_q && (cyc_q < low_len);
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sw_pad_responder.sv
module sw_pad_responder
  import swp_pkg::*;
#(
  parameter int CLKS_PER_US   = 16,
  parameter int RX_TIMEOUT_US = 8,
  parameter int REPLY_GAP_US  = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_i,
  output logic        line_drive_o,
  input  logic [11:0] btn_i,
  input  logic [7:0]  main_x_i,
  input  logic [7:0]  main_y_i,
  input  logic [7:0]  sub_x_i,
  input  logic [7:0]  sub_y_i,
  input  logic [7:0]  trig_l_i,
  input  logic [7:0]  trig_r_i
);
  localparam int GAP_N = REPLY_GAP_US * CLKS_PER_US;
  localparam int GW    = $clog2(GAP_N + 1);
  localparam logic [GW-1:0] GAP_END_C = GW'(GAP_N - 1);

  resp_state_e state_q;
  logic [GW-1:0] gap_q;
  logic line_s, line_fall;
  logic cmd_ok, tx_load, tx_busy, tx_done;
  logic [FRAME_BITS-1:0] frame;

  swp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (line_fall)
  );

  swp_rx #(.US(CLKS_PER_US), .TIMEOUT_US(RX_TIMEOUT_US)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_LISTEN),
    .line_i   (line_s),
    .fall_i   (line_fall),
    .cmd_ok_o (cmd_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LISTEN;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_LISTEN: if (cmd_ok) begin
          state_q <= ST_GAP;
          gap_q   <= '0;
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_END_C) state_q <= ST_SEND;
        end
        ST_SEND: if (tx_done) state_q <= ST_LISTEN;
        default: state_q <= ST_LISTEN;
      endcase
    end
  end

  assign tx_load = (state_q == ST_GAP) && (gap_q == GAP_END_C);
  assign frame   = build_frame(btn_i, main_x_i, main_y_i, sub_x_i, sub_y_i,
                               trig_l_i, trig_r_i);

  swp_tx #(.US(CLKS_PER_US), .FRAME_BITS(FRAME_BITS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .frame_i (frame),
    .drive_o (line_drive_o),
    .busy_o  (tx_busy),
    .done_o  (tx_done)
  );
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int US = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic drive_i,
  input logic tx_busy_i,
  input logic tx_done_i,
  input logic cmd_ok_i
);
  logic [15:0] low_cnt_q;
  logic [15:0] period_q;
  logic        prev_drive_q;
  logic        have_prev_q;
  logic        drive_start;

  assign drive_start = drive_i && !prev_drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q    <= '0;
      period_q     <= '0;
      prev_drive_q <= 1'b0;
      have_prev_q  <= 1'b0;
    end else begin
      prev_drive_q <= drive_i;
      low_cnt_q    <= drive_i ? low_cnt_q + 16'd1 : 16'd0;
      if (drive_start)          period_q <= 16'd1;
      else if (period_q != '1)  period_q <= period_q + 16'd1;
      if (!tx_busy_i)       have_prev_q <= 1'b0;
      else if (drive_start) have_prev_q <= 1'b1;
    end
  end

  assert_drive_only_in_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |-> tx_busy_i);

  assert_low_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_i && prev_drive_q) |-> (low_cnt_q == 16'(US) || low_cnt_q == 16'(3 * US)));

  assert_cell_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_start && have_prev_q && tx_busy_i) |-> (period_q == 16'(4 * US)));

  assert_released_after_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |-> !drive_i);

  assert_no_decode_while_sending_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ok_i |-> !tx_busy_i);
endmodule

bind sw_pad_responder swp_checker #(.US(CLKS_PER_US)) u_swp_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .drive_i   (line_drive_o),
  .tx_busy_i (tx_busy),
  .tx_done_i (tx_done),
  .cmd_ok_i  (cmd_ok)
);

// File: tb/sw_pad_responder_tb.sv
module sw_pad_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int US         = 8;
  localparam logic [23:0] POLL = 24'h400302;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_low = 1'b0;
  logic        drive;
  logic        line;
  logic [11:0] btn = '0;
  logic [7:0]  mx = '0, my = '0, sx = '0, sy = '0, tl = '0, tr = '0;
  int n_chk = 0;
  int n_fail = 0;

  assign line = ~(host_low | drive);

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_pad_responder #(.CLKS_PER_US(US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .line_drive_o(drive),
    .btn_i(btn), .main_x_i(mx), .main_y_i(my), .sub_x_i(sx), .sub_y_i(sy),
    .trig_l_i(tl), .trig_r_i(tr)
  );

  function automatic logic [64:0] exp_reply(input logic [11:0] b,
      input logic [7:0] a0, a1, a2, a3, a4, a5);
    logic [7:0] byte0, byte1;
    byte0 = {3'b000, b[4], b[3], b[2], b[1], b[0]};
    byte1 = {1'b1, b[11], b[10], b[9], b[8], b[7], b[6], b[5]};
    return {byte0, byte1, a0, a1, a2, a3, a4, a5, 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [64:0] act,
                       input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) host_low = 1'b1;
    repeat ((b ? 1 : 3) * US) @(negedge clk);
    host_low = 1'b0;
    repeat ((b ? 3 : 1) * US - 1) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [23:0] c, input logic stop);
    for (int i = 23; i >= 0; i--) send_bit(c[i]);
    send_bit(stop);
  endtask

  task automatic get_reply(output logic [64:0] bits, output int n);
    int t;
    bits = '0;
    n = 0;
    for (int i = 0; i < 70; i++) begin
      t = 0;
      while (line !== 1'b0 && t < 40 * US) begin @(negedge clk); t++; end
      if (line !== 1'b0) break;
      repeat (2 * US) @(negedge clk);
      bits = {bits[63:0], line};
      n++;
      t = 0;
      while (line === 1'b0 && t < 8 * US) begin @(negedge clk); t++; end
    end
  endtask

  task automatic poll_and_check(input string tag);
    logic [64:0] r, e;
    int n;
    e = exp_reply(btn, mx, my, sx, sy, tl, tr);
    send_cmd(POLL, 1'b1);
    get_reply(r, n);
    check(n == 65, {tag, " R4 bit count"}, 65'(n), 65'd65);
    check(r == e, {tag, " R2 full reply"}, r, e);
    check(r[64:57] == e[64:57], {tag, " R5 byte0"}, 65'(r[64:57]), 65'(e[64:57]));
    check(r[56:49] == e[56:49], {tag, " R6 byte1"}, 65'(r[56:49]), 65'(e[56:49]));
    check(r[48:1] == e[48:1], {tag, " R7 analog"}, 65'(r[48:1]), 65'(e[48:1]));
    check(r[0] == 1'b1, {tag, " R4 stop bit"}, 65'(r[0]), 65'd1);
  endtask

  task automatic expect_silence(input string tag);
    logic [64:0] r;
    int n;
    get_reply(r, n);
    check(n == 0, tag, 65'(n), 65'd0);
  endtask

  task automatic randomize_inputs();
    btn = 12'($urandom);
    mx = 8'($urandom); my = 8'($urandom); sx = 8'($urandom);
    sy = 8'($urandom); tl = 8'($urandom); tr = 8'($urandom);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [64:0] r, e;
    int n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(drive == 1'b0, "R1 drive in reset", 65'(drive), 65'd0);
    rst_n = 1'b1;
    repeat (20 * US) @(negedge clk);
    check(drive == 1'b0 && line == 1'b1, "R1 idle after reset", 65'(drive), 65'd0);

    btn = '0; {mx, my, sx, sy, tl, tr} = '0;
    poll_and_check("zeros");
    btn = 12'hfff; {mx, my, sx, sy, tl, tr} = '1;
    poll_and_check("ones");
    btn = 12'h015; mx = 8'h80; my = 8'h7f; sx = 8'h01; sy = 8'hfe; tl = 8'h3c; tr = 8'hc3;
    poll_and_check("pattern");

    send_cmd(24'h400303, 1'b1);
    expect_silence("R8 wrong command");
    send_cmd(24'hc00302, 1'b1);
    expect_silence("R8 wrong msb");
    send_cmd(POLL, 1'b0);
    expect_silence("R8 stop bit zero");

    // R9: partial command then stall beyond timeout
    for (int i = 23; i >= 14; i--) send_bit(POLL[i]);
    repeat (12 * US) @(negedge clk);
    poll_and_check("R9 after timeout");

    // R10: inputs change right after reply starts
    btn = 12'h5a3; mx = 8'h11; my = 8'h22; sx = 8'h33; sy = 8'h44; tl = 8'h55; tr = 8'h66;
    e = exp_reply(btn, mx, my, sx, sy, tl, tr);
    send_cmd(POLL, 1'b1);
    fork
      get_reply(r, n);
      begin
        wait (line === 1'b0);
        @(negedge clk);
        btn = ~btn; mx = ~mx; my = ~my; sx = ~sx; sy = ~sy; tl = ~tl; tr = ~tr;
      end
    join
    check(n == 65 && r == e, "R10 latched inputs", r, e);

    // R11: back-to-back polls with changing inputs
    for (int k = 0; k < 3; k++) begin
      randomize_inputs();
      poll_and_check("R11 back-to-back");
    end

    for (int k = 0; k < 12; k++) begin
      randomize_inputs();
      poll_and_check("random");
    end

    check(drive == 1'b0, "R4 released at end", 65'(drive), 65'd0);
    finish_run();
  end
endmodule